// File: doc/BRIEF.md
# Second-Level Cache Region Maintenance Controller

This block is the maintenance front end of a shared second-level cache. Software reaches it through a small register file. Through that file it can do three things:

- clean the whole cache;
- drop the whole cache;
- clean or drop a window of physical addresses.

The block keeps a direct-mapped tag/valid/dirty array of `SETS` entries. The cache pipeline keeps that array current through a fill port. The block walks the array line by line and sends each dirty line that must be cleaned out through a request/acknowledge write-back port.

A window operation is set up in two steps. The window's last address is written first. Writing the window's first address then launches the walk. The kind of window operation comes from a 3-bit opcode in the control register, combined with the invalidate-mode bit. The busy flag in the control register stays high from launch until the last write-back has been acknowledged. While it is high, register writes and fills are held off.

The line size is 128 bytes when `lineSel` is 0 and 64 bytes when it is 1. The upper-address window registers are present for software compatibility but always read as zero.

Top module: `l2_region_maint`

## Requirements
- R1: After reset the block is idle (`wrReady`=1, `wbReq`=0), the array holds no valid line, and the control register (select 0) reads zero.
- R2: The control register (select 0) holds disable at bit 0, invalidate-mode at bit 6 and the window opcode at bits 11..9. It reads busy at bit 8 and zero at every other bit, whatever was written there.
- R3: The upper-address end (select 5) and start (select 6) registers always read zero; writes to them have no effect.
- R4: A write to select 2 (whole flush) writes back every valid dirty line once, in set order, and leaves it valid and clean. A whole walk takes exactly `SETS` busy cycles when no write-back is needed.
- R5: A write to select 1 (whole invalidate) drops every line without write-back when invalidate-mode is 0. When invalidate-mode is 1, it first writes back the dirty lines, then drops them.
- R6: A write to select 4 (window first address) launches a window walk. Opcode 001 drops lines, with a prior write-back of dirty lines when invalidate-mode is 1. Every other opcode, 000 included, cleans lines and keeps them valid.
- R7: A window covers every line from the line holding the first address (select 4) through the line holding the last address (select 3), both inclusive. Address bits below the line size are ignored, and only entries whose stored tag matches the line are touched.
- R8: A window whose last line is below its first line performs no line operation and no write-back, and holds busy for exactly one cycle.
- R9: Busy (low `wrReady`, bit 8 of select 0) rises in the cycle after a launching write and falls once the last line is done. `wbReq` is raised only while busy, and it holds with a stable `wbAddr` until `wbAck`.
- R10: Register writes presented while busy are not taken and leave all register contents unchanged.
- R11: Fills are ignored while the disable bit is set or while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineSel | input | 1 | Line size select: 0 = 128 bytes, 1 = 64 bytes |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select for writes |
| wrData | input | AW | Register write data |
| wrReady | output | 1 | High when a write is taken (not busy) |
| rdSel | input | 3 | Register select for reads |
| rdData | output | AW | Register read data (combinational) |
| fillEn | input | 1 | Pipeline records a line in the tag array |
| fillAddr | input | AW | Address of the recorded line |
| fillDirty | input | 1 | Dirty state of the recorded line |
| wbReq | output | 1 | Write-back request |
| wbAddr | output | AW | Line-aligned write-back address |
| wbAck | input | 1 | Write-back acknowledge |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:

- **Window end points.** The window's first and last addresses are placed mid-line. A design that used byte addresses instead of line numbers, or treated the last line as exclusive, would skip or add write-backs.
- **Tag aliasing.** A window covers a set whose entry belongs to another tag. A design that matched on index alone would write back a line it must not touch.
- **Reversed window.** The bench checks that busy lasts one cycle with no traffic. A design that compared unsigned differences would instead walk almost the whole address space.
- **Opcode and mode decode, hold-off.** Every opcode/invalidate-mode pairing is exercised. Writes and fills are driven while a slow-acknowledged walk is in progress, to catch a design that lets them through.

// File: rtl/rgn_maint_pkg.sv
package rgn_maint_pkg;

  localparam int LOG_LINE_SMALL = 6;
  localparam int LOG_LINE_BIG   = 7;

  localparam logic [2:0] SEL_CTRL      = 3'd0;
  localparam logic [2:0] SEL_ALL_INV   = 3'd1;
  localparam logic [2:0] SEL_ALL_FLUSH = 3'd2;
  localparam logic [2:0] SEL_RGN_END   = 3'd3;
  localparam logic [2:0] SEL_RGN_START = 3'd4;
  localparam logic [2:0] SEL_END_HI    = 3'd5;
  localparam logic [2:0] SEL_START_HI  = 3'd6;

  localparam int BIT_DIS   = 0;
  localparam int BIT_INV   = 6;
  localparam int BIT_BUSY  = 8;
  localparam int OPC_LO    = 9;
  localparam int OPC_HI    = 11;
  localparam logic [2:0] OPC_DROP = 3'b001;

  typedef enum logic [1:0] {
    KIND_CLEAN      = 2'd0,
    KIND_DROP       = 2'd1,
    KIND_CLEAN_DROP = 2'd2
  } opKind_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_WB   = 2'd2,
    ST_DONE = 2'd3
  } walkState_t;

  typedef struct packed {
    logic loadRegion;
    logic loadEntire;
    logic advance;
    logic clrValid;
    logic clrDirty;
    logic fillOk;
  } walkStrb_t;

endpackage

// File: rtl/rgn_maint_walk.sv
module rgn_maint_walk
  import rgn_maint_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SETS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  walkStrb_t       strb,
  input  logic            lineSel,
  input  logic [AW-1:0]   startAddr,
  input  logic [AW-1:0]   endAddr,
  input  logic [AW-1:0]   fillAddr,
  input  logic            fillDirty,
  output logic            curHit,
  output logic            curDirty,
  output logic            atLast,
  output logic            rangeEmpty,
  output logic [AW-1:0]   wbAddr
);

  localparam int IDX_W = $clog2(SETS);
  localparam int LN_W  = AW - LOG_LINE_SMALL;
  localparam int TAG_W = LN_W - IDX_W;
  localparam int PAD_W = AW - LN_W;

  function automatic logic [LN_W-1:0] toLine(input logic [AW-1:0] a, input logic sel);
    logic [AW-1:0] s;
    s = sel ? (a >> LOG_LINE_SMALL) : (a >> LOG_LINE_BIG);
    return s[LN_W-1:0];
  endfunction

  logic [LN_W-1:0]  curQ, lastQ;
  logic             regionQ;
  logic [IDX_W-1:0] curIdx;
  logic [TAG_W-1:0] curTag;
  logic [LN_W-1:0]  fillLine, wbLine;
  logic [IDX_W-1:0] fillIdx;
  logic [TAG_W-1:0] fillTag;

  logic             validV [SETS];
  logic             dirtyV [SETS];
  logic [TAG_W-1:0] tagV   [SETS];

  assign curIdx   = curQ[IDX_W-1:0];
  assign curTag   = curQ[LN_W-1:IDX_W];
  assign fillLine = toLine(fillAddr, lineSel);
  assign fillIdx  = fillLine[IDX_W-1:0];
  assign fillTag  = fillLine[LN_W-1:IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ    <= '0;
      lastQ   <= '0;
      regionQ <= 1'b0;
    end else if (strb.loadRegion) begin
      curQ    <= toLine(startAddr, lineSel);
      lastQ   <= toLine(endAddr, lineSel);
      regionQ <= 1'b1;
    end else if (strb.loadEntire) begin
      curQ    <= '0;
      lastQ   <= LN_W'(SETS - 1);
      regionQ <= 1'b0;
    end else if (strb.advance) begin
      curQ    <= curQ + LN_W'(1);
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             vQ, dQ;
    logic [TAG_W-1:0] tQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vQ <= 1'b0;
        dQ <= 1'b0;
        tQ <= '0;
      end else if (strb.fillOk && fillIdx == IDX_W'(s)) begin
        vQ <= 1'b1;
        dQ <= fillDirty;
        tQ <= fillTag;
      end else if (curIdx == IDX_W'(s)) begin
        if (strb.clrValid) vQ <= 1'b0;
        if (strb.clrDirty) dQ <= 1'b0;
      end
    end
    assign validV[s] = vQ;
    assign dirtyV[s] = dQ;
    assign tagV[s]   = tQ;
  end

  assign curHit     = validV[curIdx] && (!regionQ || tagV[curIdx] == curTag);
  assign curDirty   = dirtyV[curIdx];
  assign atLast     = (curQ == lastQ);
  assign rangeEmpty = toLine(endAddr, lineSel) < toLine(startAddr, lineSel);
  assign wbLine     = regionQ ? curQ : {tagV[curIdx], curIdx};
  assign wbAddr     = lineSel ? ({{PAD_W{1'b0}}, wbLine} << LOG_LINE_SMALL)
                              : ({{PAD_W{1'b0}}, wbLine} << LOG_LINE_BIG);

endmodule

// File: rtl/rgn_maint_ctrl.sv
module rgn_maint_ctrl
  import rgn_maint_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrSel,
  input  logic [AW-1:0] wrData,
  output logic          wrReady,
  input  logic [2:0]    rdSel,
  output logic [AW-1:0] rdData,
  input  logic          fillEn,
  output logic          wbReq,
  input  logic          wbAck,
  input  logic          curHit,
  input  logic          curDirty,
  input  logic          atLast,
  input  logic          rangeEmpty,
  output logic [AW-1:0] endAddr,
  output walkStrb_t     strb
);

  walkState_t    stateQ, stateN;
  opKind_t       kindQ, kindN;
  logic          disQ, invQ;
  logic [2:0]    opcQ;
  logic [AW-1:0] endQ, startQ;
  logic          acc, busy, needWb;

  assign busy    = (stateQ != ST_IDLE);
  assign wrReady = !busy;
  assign acc     = wrEn && !busy;
  assign wbReq   = (stateQ == ST_WB);
  assign endAddr = endQ;
  assign needWb  = curHit && curDirty && (kindQ != KIND_DROP);

  always_comb begin
    strb            = '0;
    stateN          = stateQ;
    kindN           = kindQ;
    strb.fillOk     = fillEn && !busy && !disQ;
    strb.loadEntire = acc && (wrSel == SEL_ALL_INV || wrSel == SEL_ALL_FLUSH);
    strb.loadRegion = acc && (wrSel == SEL_RGN_START);
    unique case (stateQ)
      ST_IDLE: begin
        if (strb.loadEntire) begin
          stateN = ST_WALK;
          if (wrSel == SEL_ALL_INV) kindN = invQ ? KIND_CLEAN_DROP : KIND_DROP;
          else                      kindN = KIND_CLEAN;
        end else if (strb.loadRegion) begin
          stateN = rangeEmpty ? ST_DONE : ST_WALK;
          if (opcQ == OPC_DROP) kindN = invQ ? KIND_CLEAN_DROP : KIND_DROP;
          else                  kindN = KIND_CLEAN;
        end
      end
      ST_WALK: begin
        if (needWb) begin
          stateN = ST_WB;
        end else begin
          strb.advance  = 1'b1;
          strb.clrValid = curHit && (kindQ != KIND_CLEAN);
          strb.clrDirty = curHit && (kindQ != KIND_CLEAN);
          if (atLast) stateN = ST_IDLE;
        end
      end
      ST_WB: begin
        if (wbAck) begin
          strb.advance  = 1'b1;
          strb.clrDirty = 1'b1;
          strb.clrValid = (kindQ == KIND_CLEAN_DROP);
          stateN        = atLast ? ST_IDLE : ST_WALK;
        end
      end
      ST_DONE: stateN = ST_IDLE;
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      kindQ  <= KIND_CLEAN;
      disQ   <= 1'b0;
      invQ   <= 1'b0;
      opcQ   <= '0;
      endQ   <= '0;
      startQ <= '0;
    end else begin
      stateQ <= stateN;
      kindQ  <= kindN;
      if (acc) begin
        case (wrSel)
          SEL_CTRL: begin
            disQ <= wrData[BIT_DIS];
            invQ <= wrData[BIT_INV];
            opcQ <= wrData[OPC_HI:OPC_LO];
          end
          SEL_RGN_END:   endQ   <= wrData;
          SEL_RGN_START: startQ <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_CTRL: begin
        rdData[BIT_DIS]       = disQ;
        rdData[BIT_INV]       = invQ;
        rdData[BIT_BUSY]      = busy;
        rdData[OPC_HI:OPC_LO] = opcQ;
      end
      SEL_RGN_END:   rdData = endQ;
      SEL_RGN_START: rdData = startQ;
      default:       rdData = '0;
    endcase
  end

endmodule

// File: rtl/l2_region_maint.sv
module l2_region_maint
  import rgn_maint_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SETS = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lineSel,
  input  logic          wrEn,
  input  logic [2:0]    wrSel,
  input  logic [AW-1:0] wrData,
  output logic          wrReady,
  input  logic [2:0]    rdSel,
  output logic [AW-1:0] rdData,
  input  logic          fillEn,
  input  logic [AW-1:0] fillAddr,
  input  logic          fillDirty,
  output logic          wbReq,
  output logic [AW-1:0] wbAddr,
  input  logic          wbAck
);

  walkStrb_t     strb;
  logic          curHit, curDirty, atLast, rangeEmpty;
  logic [AW-1:0] endAddr;

  rgn_maint_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .wrReady(wrReady),
    .rdSel(rdSel), .rdData(rdData),
    .fillEn(fillEn), .wbReq(wbReq), .wbAck(wbAck),
    .curHit(curHit), .curDirty(curDirty), .atLast(atLast),
    .rangeEmpty(rangeEmpty), .endAddr(endAddr), .strb(strb)
  );

  rgn_maint_walk #(.AW(AW), .SETS(SETS)) u_walk (
    .clk(clk), .rstN(rstN), .strb(strb), .lineSel(lineSel),
    .startAddr(wrData), .endAddr(endAddr),
    .fillAddr(fillAddr), .fillDirty(fillDirty),
    .curHit(curHit), .curDirty(curDirty), .atLast(atLast),
    .rangeEmpty(rangeEmpty), .wbAddr(wbAddr)
  );

endmodule

// File: rtl/rgn_maint_chk.sv
module rgn_maint_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [2:0]    wrSel,
  input logic          wrReady,
  input logic [2:0]    rdSel,
  input logic [AW-1:0] rdData,
  input logic          wbReq,
  input logic [AW-1:0] wbAddr,
  input logic          wbAck
);

  assert_wb_when_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> !wrReady);

  assert_wb_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> (wbReq && $stable(wbAddr)));

  assert_launch_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrReady && (wrSel == 3'd1 || wrSel == 3'd2 || wrSel == 3'd4)) |=> !wrReady);

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == 3'd5 || rdSel == 3'd6) |-> (rdData == '0));

  assert_busy_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == 3'd0) |-> (rdData[8] == !wrReady));

  assert_plain_write_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrReady && (wrSel == 3'd0 || wrSel == 3'd3)) |=> wrReady);

endmodule

bind l2_region_maint rgn_maint_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrReady(wrReady),
  .rdSel(rdSel), .rdData(rdData), .wbReq(wbReq), .wbAddr(wbAddr), .wbAck(wbAck)
);

// File: tb/l2_region_maint_tb.sv
module l2_region_maint_tb;

  localparam int AW   = 32;
  localparam int SETS = 8;

  logic          clk = 1'b0, rstN = 1'b0, lineSel = 1'b0;
  logic          wrEn = 1'b0, fillEn = 1'b0, fillDirty = 1'b0, wbAck = 1'b0;
  logic [2:0]    wrSel = '0, rdSel = '0;
  logic [AW-1:0] wrData = '0, fillAddr = '0;
  logic          wrReady, wbReq;
  logic [AW-1:0] rdData, wbAddr;

  always #10 clk = ~clk;

  l2_region_maint #(.AW(AW), .SETS(SETS)) u_dut (
    .clk(clk), .rstN(rstN), .lineSel(lineSel),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .wrReady(wrReady),
    .rdSel(rdSel), .rdData(rdData),
    .fillEn(fillEn), .fillAddr(fillAddr), .fillDirty(fillDirty),
    .wbReq(wbReq), .wbAddr(wbAddr), .wbAck(wbAck)
  );

  int nChk = 0, nFail = 0, wbCount = 0, ackLat = 0, waitCnt = 0;
  bit finished = 0;

  // behavioural reference model
  bit          mV[SETS], mD[SETS];
  int unsigned mT[SETS];
  bit          mDis, mInv, mRegion;
  bit [2:0]    mOp;
  bit [31:0]   mEnd;
  int          mState, mKind;   // state 0 idle 1 walk 2 wb 3 done; kind 0 clean 1 drop 2 clean+drop
  int unsigned mLines[$];

  function automatic int unsigned lineOf(bit [31:0] a);
    return lineSel ? (a >> 6) : (a >> 7);
  endfunction

  function automatic bit [31:0] expAddr();
    int unsigned l, idx, ln;
    l = mLines[0];
    idx = l % SETS;
    ln = mRegion ? l : (mT[idx] * SETS + idx);
    return lineSel ? (ln << 6) : (ln << 7);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mKind = 0; mDis = 0; mInv = 0; mOp = 0; mEnd = 0; mRegion = 0;
      mLines.delete();
      for (int i = 0; i < SETS; i++) begin mV[i] = 0; mD[i] = 0; mT[i] = 0; end
    end else begin
      case (mState)
        0: begin
          if (fillEn && !mDis) begin
            int unsigned ln;
            ln = lineOf(fillAddr);
            mV[ln % SETS] = 1; mD[ln % SETS] = fillDirty; mT[ln % SETS] = ln / SETS;
          end
          if (wrEn) begin
            case (wrSel)
              3'd0: begin mDis = wrData[0]; mInv = wrData[6]; mOp = wrData[11:9]; end
              3'd1, 3'd2: begin
                mKind = (wrSel == 3'd2) ? 0 : (mInv ? 2 : 1);
                mRegion = 0; mLines.delete();
                for (int i = 0; i < SETS; i++) mLines.push_back(i);
                mState = 1;
              end
              3'd3: mEnd = wrData;
              3'd4: begin
                mKind = (mOp == 3'b001) ? (mInv ? 2 : 1) : 0;
                mRegion = 1; mLines.delete();
                if (lineOf(mEnd) < lineOf(wrData)) mState = 3;
                else begin
                  for (int unsigned l = lineOf(wrData); l <= lineOf(mEnd); l++) mLines.push_back(l);
                  mState = 1;
                end
              end
              default: ;
            endcase
          end
        end
        1: begin
          int unsigned l, idx;
          bit hit;
          l = mLines[0]; idx = l % SETS;
          hit = mV[idx] && (!mRegion || mT[idx] == l / SETS);
          if (hit && mD[idx] && mKind != 1) mState = 2;
          else begin
            if (hit && mKind != 0) begin mV[idx] = 0; mD[idx] = 0; end
            void'(mLines.pop_front());
            if (mLines.size() == 0) mState = 0;
          end
        end
        2: if (wbAck) begin
          int unsigned idx;
          idx = mLines[0] % SETS;
          mD[idx] = 0;
          if (mKind == 2) mV[idx] = 0;
          void'(mLines.pop_front());
          mState = (mLines.size() == 0) ? 0 : 1;
        end
        default: mState = 0;
      endcase
    end
  end

  // write-back acknowledge driver with programmable latency
  always @(negedge clk) begin
    if (mState == 2) begin
      wbAck = (waitCnt >= ackLat);
      waitCnt++;
    end else begin
      wbAck = 0; waitCnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN && !finished) begin
      chk(wrReady == (mState == 0), "R9", "ready vs busy", wrReady, mState == 0);
      chk(wbReq == (mState == 2), "R9", "wbReq", wbReq, mState == 2);
      if (wbReq && mState == 2) chk(wbAddr == expAddr(), "R7", "wbAddr", wbAddr, expAddr());
      if (wbReq && wbAck) wbCount++;
    end
  end

  task automatic regWr(input bit [2:0] s, input bit [31:0] d);
    @(negedge clk);
    while (!wrReady) @(negedge clk);
    wrEn = 1; wrSel = s; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic runOp(input bit [2:0] s, input bit [31:0] d, output int busyCyc, output int wbs);
    int base;
    base = wbCount;
    regWr(s, d);
    busyCyc = 0;
    #2;
    while (!wrReady) begin busyCyc++; @(negedge clk); #2; end
    wbs = wbCount - base;
  endtask

  task automatic fillLine(input bit [31:0] a, input bit dirty);
    @(negedge clk);
    fillEn = 1; fillAddr = a; fillDirty = dirty;
    @(negedge clk);
    fillEn = 0;
  endtask

  task automatic rdReg(input bit [2:0] s, output bit [31:0] d);
    @(negedge clk);
    rdSel = s;
    #2;
    d = rdData;
  endtask

  task automatic region(input bit [31:0] first, input bit [31:0] last,
                        output int busyCyc, output int wbs);
    regWr(3'd3, last);
    runOp(3'd4, first, busyCyc, wbs);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    int bc, wb;
    bit [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1;
    #2;
    // R1 reset state
    chk(wrReady == 1, "R1", "wrReady after reset", wrReady, 1);
    chk(wbReq == 0, "R1", "wbReq after reset", wbReq, 0);
    rdReg(3'd0, rd); chk(rd == 0, "R1", "ctrl after reset", rd, 0);
    runOp(3'd2, 0, bc, wb); chk(wb == 0, "R1", "no valid line after reset", wb, 0);

    // R2 control fields
    regWr(3'd0, 32'hFFFF_FFFF);
    rdReg(3'd0, rd); chk(rd == 32'h0000_0E41, "R2", "ctrl readback", rd, 32'h0E41);
    regWr(3'd0, 0);
    rdReg(3'd0, rd); chk(rd == 0, "R2", "ctrl cleared", rd, 0);

    // R3 upper registers
    regWr(3'd5, 32'h1234_5678); regWr(3'd6, 32'hFFFF_FFFF);
    rdReg(3'd5, rd); chk(rd == 0, "R3", "upper end", rd, 0);
    rdReg(3'd6, rd); chk(rd == 0, "R3", "upper start", rd, 0);

    // R4 whole flush, 128-byte lines
    ackLat = 1;
    fillLine(32'h000, 1); fillLine(32'h080, 0); fillLine(32'h500, 1); fillLine(32'hD80, 1);
    runOp(3'd2, 0, bc, wb); chk(wb == 3, "R4", "whole flush write-backs", wb, 3);
    runOp(3'd2, 0, bc, wb); chk(wb == 0, "R4", "second flush clean", wb, 0);
    chk(bc == SETS, "R4", "clean whole walk busy cycles", bc, SETS);

    // R5 whole invalidate
    runOp(3'd1, 0, bc, wb); chk(wb == 0, "R5", "invalidate mode 0 no write-back", wb, 0);
    fillLine(32'h000, 1); fillLine(32'h500, 1); fillLine(32'hD80, 0);
    regWr(3'd0, 32'h040);
    runOp(3'd1, 0, bc, wb); chk(wb == 2, "R5", "invalidate mode 1 write-backs", wb, 2);
    runOp(3'd2, 0, bc, wb); chk(wb == 0, "R5", "lines dropped", wb, 0);

    // R6/R7 window flush with mid-line end points
    regWr(3'd0, 0); ackLat = 0;
    fillLine(32'h200, 1); fillLine(32'h280, 1); fillLine(32'h300, 1); fillLine(32'h380, 1);
    region(32'h285, 32'h303, bc, wb); chk(wb == 2, "R7", "inclusive window flush", wb, 2);
    runOp(3'd2, 0, bc, wb); chk(wb == 2, "R6", "flush kept others dirty", wb, 2);
    fillLine(32'h680, 1);
    region(32'h280, 32'h2FF, bc, wb); chk(wb == 0, "R7", "tag mismatch untouched", wb, 0);
    runOp(3'd2, 0, bc, wb); chk(wb == 1, "R7", "aliased line still dirty", wb, 1);

    // R6 opcode decode
    fillLine(32'h100, 1); fillLine(32'h180, 1);
    regWr(3'd0, 32'h200);
    region(32'h100, 32'h1FF, bc, wb); chk(wb == 0, "R6", "opcode 001 drop", wb, 0);
    runOp(3'd2, 0, bc, wb); chk(wb == 0, "R6", "dropped lines gone", wb, 0);
    fillLine(32'h100, 1); fillLine(32'h180, 1);
    regWr(3'd0, 32'h240); ackLat = 2;
    region(32'h100, 32'h180, bc, wb); chk(wb == 2, "R6", "opcode 001 clean+drop", wb, 2);
    runOp(3'd2, 0, bc, wb); chk(wb == 0, "R6", "clean+drop left nothing", wb, 0);
    fillLine(32'h100, 1);
    regWr(3'd0, 32'hA00);
    region(32'h100, 32'h100, bc, wb); chk(wb == 1, "R6", "opcode 101 cleans", wb, 1);

    // R7 64-byte lines
    regWr(3'd0, 0);
    runOp(3'd1, 0, bc, wb);
    lineSel = 1;
    fillLine(32'h040, 1); fillLine(32'h080, 1); fillLine(32'h0C0, 1);
    region(32'h041, 32'h0BF, bc, wb); chk(wb == 2, "R7", "64-byte window", wb, 2);
    runOp(3'd2, 0, bc, wb); chk(wb == 1, "R7", "64-byte rest", wb, 1);
    runOp(3'd1, 0, bc, wb);
    @(negedge clk); lineSel = 0;

    // R8 reversed window, and same-line window
    fillLine(32'h400, 1);
    region(32'h400, 32'h3FF, bc, wb);
    chk(bc == 1, "R8", "reversed window busy cycles", bc, 1);
    chk(wb == 0, "R8", "reversed window no traffic", wb, 0);
    region(32'h47F, 32'h401, bc, wb); chk(wb == 1, "R7", "same-line window", wb, 1);

    // R10/R11 hold-off while busy
    ackLat = 3;
    fillLine(32'h000, 1); fillLine(32'h080, 1);
    wb = wbCount;
    regWr(3'd2, 0);
    wrEn = 1; wrSel = 3'd0; wrData = 32'h41;
    fillEn = 1; fillAddr = 32'h100; fillDirty = 1;
    #2; chk(wrReady == 0, "R10", "wrReady low while busy", wrReady, 0);
    @(negedge clk); @(negedge clk);
    wrEn = 0; fillEn = 0;
    #2; while (!wrReady) begin @(negedge clk); #2; end
    chk(wbCount - wb == 2, "R9", "write-backs with slow ack", wbCount - wb, 2);
    rdReg(3'd0, rd); chk(rd == 0, "R10", "ctrl unchanged by held write", rd, 0);
    runOp(3'd2, 0, bc, wb); chk(wb == 0, "R11", "fill during busy ignored", wb, 0);

    // R11 fills ignored while disabled
    regWr(3'd0, 32'h001);
    rdReg(3'd0, rd); chk(rd == 1, "R2", "disable bit", rd, 1);
    fillLine(32'h180, 1);
    regWr(3'd0, 0);
    runOp(3'd2, 0, bc, wb); chk(wb == 0, "R11", "fill while disabled ignored", wb, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule